// File: doc/BRIEF.md
# Configurable GPIO Port Register File

This block is one bidirectional I/O port of parallel width (eight bits by default) whose behaviour is held in three memory-mapped registers on a simple register bus: a mode register, an output-value register and a read-only pin register. Each pin takes its mode from the matching bit of the mode register and the matching bit of the output-value register. That bit pair selects one of four behaviours: floating input, input with a weak pull-up, drive low, or drive high. The block produces a per-pin output enable, output value and pull-up enable for the pad ring. It reads the pin levels back through a two-stage synchronizer.

A build parameter enables a special-function variant. In that variant the two top output-value bits are not storage. Writing a one to bit 7 asks for a stop-clock (halt) state, and writing a one to bit 6 asks for an idle state. Each request appears as a single-cycle pulse. These two bits always read back as zero, and pins 6 and 7 act only as plain inputs. The two top mode-register bits are stored and fan out as controls. Bit 6 selects the opposite serial-clock phase, and bit 7 enables a start-up delay after a halt.

Top module: `gpio_port`

## Requirements
- R1: While reset is high and on the first cycle after it, both registers hold zero, every output enable and pull-up enable is 0, and the halt and idle pulses are low.
- R2: A pin whose mode bit is 0 and output-value bit is 0 is a floating input: output enable 0, pull-up 0, output value 0.
- R3: A pin whose mode bit is 0 and output-value bit is 1 is an input with pull-up: output enable 0, pull-up 1, output value 0.
- R4: A pin whose mode bit is 1 drives its output-value bit: output enable 1, pull-up 0, output value equal to the output-value bit.
- R5: Address map on the 2-bit bus address: 0 is the mode register (read/write), 1 is the output-value register (read/write), 2 is the pin register (read-only; writes there change nothing), and 3 reads as zero.
- R6: A write takes effect on the rising clock edge where the write strobe is high, and not before. Read data is combinational from the addressed register.
- R7: A level change on a pin input shows in the pin register after the second rising edge and not after the first.
- R8: In the special-function variant, a write to address 1 with bit 7 set raises the halt request for exactly the one cycle after that edge.
- R9: In the special-function variant, a write to address 1 with bit 6 set raises the idle request for exactly the one cycle after that edge.
- R10: In the special-function variant, output-value bits 6 and 7 always read as zero, and pins 6 and 7 are never driven or pulled up.
- R11: In the special-function variant, the serial-clock phase select follows mode bit 6 and the start-up delay enable follows mode bit 7. Both read back through address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data |
| pin_in | input | W | Raw pin levels |
| pin_oe | output | W | Per-pin output enable |
| pin_out | output | W | Per-pin output value |
| pin_pu | output | W | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request pulse |
| idle_req | output | 1 | One-cycle idle request pulse |
| sk_alt_phase | output | 1 | Alternate serial-clock phase select |
| wake_delay_en | output | 1 | Start-up delay enable after halt |

## Verification
The bench sweeps every mode-register value against several output-value patterns. For each pair it checks all three pad controls per pin. A design that swapped the pull-up and drive cases, or that drove pins 6 and 7, would show a mismatch on the affected bits. Further checks target the pin-register latency, a write to the read-only address, and reads of the spare address. A one-stage synchronizer would show the new level one cycle early. A write decoder that landed on the wrong register would corrupt the mode or output-value readback. The halt and idle pulses are checked to last exactly one cycle. The reads of output-value bits 6 and 7 are checked to return zero, which exposes a design that stores those bits or holds the pulse high.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_OVAL = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic oe;
        logic drv;
        logic pu;
    } pad_ctl_t;

    localparam int HALT_BIT = 7;
    localparam int IDLE_BIT = 6;

    // Mode-bit / value-bit pair to pad controls.
    function automatic pad_ctl_t decode_mode(input logic mode_b, input logic val_b);
        pad_ctl_t c;
        c.oe  = mode_b;
        c.drv = mode_b & val_b;
        c.pu  = ~mode_b & val_b;
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;

    // R7
    sync_stage_chk: assert property (@(posedge clk) disable iff (rst)
        stage2_q == $past(stage1_q));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W       = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   addr,
    input  logic         wen,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] oval_q,
    output logic         halt_req,
    output logic         idle_req
);
    localparam logic [W-1:0] SF_MASK = SPECIAL ? (W'(2'b11) << IDLE_BIT) : '0;

    port_sel_e sel;
    logic      wr_mode;
    logic      wr_oval;

    assign sel     = port_sel_e'(addr);
    assign wr_mode = wen && (sel == SEL_MODE);
    assign wr_oval = wen && (sel == SEL_OVAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            oval_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_oval) oval_q <= wdata & ~SF_MASK;
        end
    end

    generate
        if (SPECIAL) begin : g_sf
            logic halt_q;
            logic idle_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    halt_q <= 1'b0;
                    idle_q <= 1'b0;
                end else begin
                    halt_q <= wr_oval && wdata[HALT_BIT];
                    idle_q <= wr_oval && wdata[IDLE_BIT];
                end
            end
            assign halt_req = halt_q;
            assign idle_req = idle_q;

            // R8
            halt_src_chk: assert property (@(posedge clk) disable iff (rst)
                halt_req |-> $past(wen) && $past(addr) == 2'd1);
            // R9
            idle_src_chk: assert property (@(posedge clk) disable iff (rst)
                idle_req |-> $past(wen) && $past(addr) == 2'd1);
            // R10
            sf_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (oval_q & SF_MASK) == '0);
        end else begin : g_plain
            assign halt_req = 1'b0;
            assign idle_req = 1'b0;
        end
    endgenerate

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '0 && oval_q == '0));
    // R6
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && addr == 2'd0) |=> mode_q == $past(wdata));
    // R5
    pins_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && addr == 2'd2) |=> $stable(mode_q) && $stable(oval_q));

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
    import gpio_pkg::*;
#(
    parameter int W       = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic [W-1:0] mode_q,
    input  logic [W-1:0] oval_q,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_pu
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (SPECIAL && (i == HALT_BIT || i == IDLE_BIT)) begin : g_in_only
                assign pin_oe[i]  = 1'b0;
                assign pin_out[i] = 1'b0;
                assign pin_pu[i]  = 1'b0;
            end else begin : g_gp
                pad_ctl_t ctl;
                assign ctl        = decode_mode(mode_q[i], oval_q[i]);
                assign pin_oe[i]  = ctl.oe;
                assign pin_out[i] = ctl.drv;
                assign pin_pu[i]  = ctl.pu;
            end
        end
    endgenerate

    // R2
    pad_exclusive_chk: assert final ((pin_oe & pin_pu) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W       = 8,
    parameter bit SPECIAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wen,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_pu,
    output logic         halt_req,
    output logic         idle_req,
    output logic         sk_alt_phase,
    output logic         wake_delay_en
);
    logic [W-1:0] mode_q;
    logic [W-1:0] oval_q;
    logic [W-1:0] pins_sync;

    gpio_regs #(.W(W), .SPECIAL(SPECIAL)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wen      (bus_wen),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .oval_q   (oval_q),
        .halt_req (halt_req),
        .idle_req (idle_req)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_in),
        .d_out (pins_sync)
    );

    gpio_padctl #(.W(W), .SPECIAL(SPECIAL)) u_pad (
        .mode_q  (mode_q),
        .oval_q  (oval_q),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .pin_pu  (pin_pu)
    );

    always_comb begin
        case (port_sel_e'(bus_addr))
            SEL_MODE: bus_rdata = mode_q;
            SEL_OVAL: bus_rdata = oval_q;
            SEL_PINS: bus_rdata = pins_sync;
            default:  bus_rdata = '0;
        endcase
    end

    generate
        if (SPECIAL) begin : g_sf_out
            assign sk_alt_phase  = mode_q[IDLE_BIT];
            assign wake_delay_en = mode_q[HALT_BIT];
        end else begin : g_no_sf
            assign sk_alt_phase  = 1'b0;
            assign wake_delay_en = 1'b0;
        end
    endgenerate

    // R3
    pullup_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wen && bus_addr == 2'd0 && bus_wdata == '0) |-> pin_oe == '0);

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int W = 8;
    localparam logic [W-1:0] GP = 8'h3F;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   bus_addr;
    logic         bus_wen;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_oe, pin_out, pin_pu;
    logic         halt_req, idle_req, sk_alt_phase, wake_delay_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_port #(.W(W), .SPECIAL(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .halt_req(halt_req), .idle_req(idle_req),
        .sk_alt_phase(sk_alt_phase), .wake_delay_en(wake_delay_en)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_wen = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        rst = 1'b1; bus_addr = 2'd0; bus_wen = 1'b0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, '0);
        chk("R1 pu", pin_pu, '0);
        chk("R1 pulses", {6'b0, halt_req, idle_req}, '0);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd0, v); chk("R1 mode", v, '0);
        rd(2'd1, v); chk("R1 oval", v, '0);

        // R2 R3 R4 R10 sweep over all mode values and several value patterns
        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] m, d;
                m = W'(c); d = pats[p];
                wr(2'd0, m);
                wr(2'd1, d);
                chk("R4 oe", pin_oe, m & GP);
                chk("R4 out", pin_out, m & d & GP);
                chk("R3 pu", pin_pu, ~m & d & GP);
                chk("R2 float", ~pin_oe & ~pin_pu & GP, ~m & ~d & GP);
                rd(2'd1, v); chk("R10 oval read", v, d & GP);
                rd(2'd0, v); chk("R11 mode read", v, m);
                chk("R11 controls", {6'b0, wake_delay_en, sk_alt_phase}, {6'b0, m[7], m[6]});
            end
        end

        // R6 write not visible before its edge
        wr(2'd0, 8'h00);
        @(negedge clk);
        bus_addr = 2'd0; bus_wen = 1'b1; bus_wdata = 8'h0F;
        #1; chk("R6 before edge", pin_oe, 8'h00);
        @(negedge clk);
        bus_wen = 1'b0;
        chk("R6 after edge", pin_oe, 8'h0F);

        // R5 write to pin address ignored, spare address reads zero
        wr(2'd1, 8'h33);
        wr(2'd2, 8'hFF);
        rd(2'd0, v); chk("R5 mode kept", v, 8'h0F);
        rd(2'd1, v); chk("R5 oval kept", v, 8'h33);
        chk("R5 out kept", pin_out, 8'h03);
        rd(2'd3, v); chk("R5 spare zero", v, 8'h00);

        // R8 halt pulse
        wr(2'd1, 8'h80);
        chk("R8 halt high", {7'b0, halt_req}, 8'h01);
        chk("R9 idle quiet", {7'b0, idle_req}, 8'h00);
        @(negedge clk);
        chk("R8 halt one cycle", {7'b0, halt_req}, 8'h00);
        // R9 idle pulse
        wr(2'd1, 8'h41);
        chk("R9 idle high", {7'b0, idle_req}, 8'h01);
        chk("R8 halt quiet", {7'b0, halt_req}, 8'h00);
        rd(2'd1, v); chk("R10 sf read zero", v, 8'h01);
        @(negedge clk);
        chk("R9 idle one cycle", {7'b0, idle_req}, 8'h00);

        // R7 two-edge pin latency
        pin_in = 8'h5A;
        rd(2'd2, v); chk("R7 before", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v); chk("R7 one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v); chk("R7 two edges", v, 8'h5A);
        pin_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        rd(2'd2, v); chk("R7 second pattern", v, 8'hC3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule